// File: doc/BRIEF.md
# Dual-Channel Reset Sequencing Controller

This block turns two digitized power-good signals, one per supply channel, into a pair of active-low reset outputs. Each reset is held for a programmable number of clock cycles after its channel becomes good. The block also decides when the second channel may start, and it raises a level that tells a downstream watchdog it may begin supervising. A 2-bit mode input picks one of three start-up schemes. In two schemes channel 2 waits for channel 1, and in one scheme both channels start together. The two resets are either independent or merged into one shared reset.

A global enable input forces shutdown. While it is low, both channel enables are off and both resets are held asserted. Timeout lengths come from two 24-bit period inputs given in clock cycles. Analog comparators, soft-start ramps and pad drivers are outside this block.

Top module: `rst_seq_ctrl`

## Requirements
- R1: With period P, a channel's reset output goes high after exactly P+1 rising clock edges. The count starts with the first edge at which the channel's good condition is sampled high. P=0 releases the reset right after that first edge.
- R2: With mode 2'b01 (independent-sequenced), rst1_n follows channel 1 only and rst2_n follows channel 2 only. wdog_start is high only while both resets are high.
- R3: With mode 2'b00 (merged), the good condition is fb1_good AND fb2_good, timed with tmo1. Both reset outputs are equal at all times. tmo2 has no effect. wdog_start is high only while both resets are high.
- R4: When a channel's good condition drops, its reset goes low in the same cycle, without waiting for a clock edge. When the condition returns, a full new timeout runs.
- R5: With mode 2'b10 (simultaneous), ch2_en is high whenever enable is high. Each reset follows its own channel. wdog_start is high whenever rst1_n is high, whatever the state of rst2_n.
- R6: While enable is low, ch1_en, ch2_en and wdog_start are low and rst1_n and rst2_n are low, in the same cycle. The same holds out of the synchronous reset.
- R7: wdog_start is a level. It falls in the same cycle that its start condition is lost.
- R8: Mode 2'b11 behaves exactly like mode 2'b10.
- R9: A timeout period is sampled at the edge where its countdown begins. Later changes to tmo1 or tmo2 do not affect a countdown already running.
- R10: In modes 2'b00 and 2'b01, ch2_en is low until fb1_good has been sampled high by one rising edge with enable high. After that, ch2_en stays high while enable stays high, even if fb1_good drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global enable; low forces shutdown |
| fb1_good | input | 1 | Channel 1 power-good |
| fb2_good | input | 1 | Channel 2 power-good |
| mode | input | 2 | Sequencing mode: 00 merged, 01 independent-sequenced, 1x simultaneous |
| tmo1 | input | 24 | Channel 1 timeout period in cycles |
| tmo2 | input | 24 | Channel 2 timeout period in cycles |
| ch1_en | output | 1 | Channel 1 enable |
| ch2_en | output | 1 | Channel 2 enable |
| rst1_n | output | 1 | Channel 1 reset, active low |
| rst2_n | output | 1 | Channel 2 reset, active low |
| wdog_start | output | 1 | Watchdog start level |

## Verification
Reset release is the only delayed result. After a good condition is first sampled, the reset stays low for P sampling points and is high at point P+1. The bench drives inputs on the falling edge and samples one time unit after a falling edge, so it checks both the last low cycle and the first high cycle. ch2_en in the sequenced modes is due one rising edge after fb1_good is driven. Reassertion on a dropped good, shutdown, and the watchdog level are combinational, so they are checked shortly after the driving edge, before any rising edge intervenes.

// File: rtl/rst_seq_pkg.sv
// Shared types for the reset sequencing controller.
package rst_seq_pkg;
    localparam int CNT_W = 24;

    typedef enum logic [1:0] {
        SEQ_MERGED = 2'b00,
        SEQ_INDEP  = 2'b01,
        SEQ_SIMUL  = 2'b10,
        SEQ_SIMUL2 = 2'b11
    } seq_mode_e;

    typedef struct packed {
        logic merged;   // one shared reset timed by channel 1
        logic simul;    // both channels start together
    } mode_ctl_t;
endpackage

// File: rtl/rsc_mode_decode.sv
// Decodes the 2-bit sequencing mode into control flags.
// Assumes mode is quasi-static; code 2'b11 aliases simultaneous.
module rsc_mode_decode
    import rst_seq_pkg::*;
(
    input  logic [1:0] mode,
    output mode_ctl_t  ctl
);
    // Map each code to the merged and simultaneous flags.
    always_comb begin
        ctl = '0;
        unique case (seq_mode_e'(mode))
            SEQ_MERGED: ctl.merged = 1'b1;
            SEQ_INDEP:  ctl = '0;
            SEQ_SIMUL,
            SEQ_SIMUL2: ctl.simul = 1'b1;
            default:    ctl = '0;
        endcase
    end
endmodule

// File: rtl/rsc_timeout.sv
// Per-channel reset timeout.
// The period is latched at the first edge where good is high.
// The counter then counts up to the latched period.
// done is high once the count equals the period, and only while good stays high.
// Assumes good is synchronous to clk.
module rsc_timeout #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             good,
    input  logic [CNT_W-1:0] period,
    output logic             done
);
    logic             started;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Start, count and clear the timeout window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            cnt     <= '0;
            limit   <= '0;
        end else if (!good) begin
            started <= 1'b0;
            cnt     <= '0;
        end else if (!started) begin
            started <= 1'b1;
            cnt     <= '0;
            limit   <= period;
        end else if (cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Release only while the condition still holds.
    assign done = started && good && (cnt == limit);

    // R1: a running countdown advances by one each cycle.
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (started && good && cnt != limit) |=> (cnt == $past(cnt) + 1'b1))
        else $error("p_count_step_r1");

    // R9: the latched period holds while the window runs.
    p_limit_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (started && good) |=> $stable(limit))
        else $error("p_limit_held_r9");
endmodule

// File: rtl/rst_seq_ctrl.sv
// Dual-channel reset sequencing controller (top).
// Gates the channel enables, runs one timeout per channel, and forms the reset outputs and the watchdog start level.
// Assumes fb*_good are already synchronized to clk.
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int TMO_W = CNT_W,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fb1_good,
    input  logic             fb2_good,
    input  logic [1:0]       mode,
    input  logic [TMO_W-1:0] tmo1,
    input  logic [TMO_W-1:0] tmo2,
    output logic             ch1_en,
    output logic             ch2_en,
    output logic             rst1_n,
    output logic             rst2_n,
    output logic             wdog_start
);
    mode_ctl_t        ctl;
    logic             ch2_arm;
    logic [NCH-1:0]   good_v;
    logic [NCH-1:0]   done_v;
    logic [TMO_W-1:0] period_v [NCH];

    rsc_mode_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    // Arm channel 2 once channel 1 has been seen good while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) ch2_arm <= 1'b0;
        else if (fb1_good)     ch2_arm <= 1'b1;
    end

    assign ch1_en = enable;
    assign ch2_en = enable && (ctl.simul || ch2_arm);

    // Per-channel good conditions; merged mode leaves channel 2 idle.
    always_comb begin
        good_v[0]   = enable && fb1_good && (!ctl.merged || fb2_good);
        good_v[1]   = enable && fb2_good && !ctl.merged;
        period_v[0] = tmo1;
        period_v[1] = tmo2;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_tmo
        rsc_timeout #(.CNT_W(TMO_W)) u_tmo (
            .clk    (clk),
            .rst_n  (rst_n),
            .good   (good_v[g]),
            .period (period_v[g]),
            .done   (done_v[g])
        );
    end

    // Form reset outputs and the watchdog start level.
    always_comb begin
        rst1_n     = done_v[0];
        rst2_n     = ctl.merged ? done_v[0] : done_v[1];
        wdog_start = ctl.simul ? rst1_n : (rst1_n && rst2_n);
    end

    // R6: shutdown holds everything off.
    p_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!ch1_en && !ch2_en && !rst1_n && !rst2_n && !wdog_start))
        else $error("p_shutdown_r6");

    // R3: merged mode keeps both resets equal.
    p_merged_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (rst1_n == rst2_n))
        else $error("p_merged_equal_r3");

    // R4: a lost channel-1 good forces reset at once.
    p_drop_reasserts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fb1_good |-> !rst1_n)
        else $error("p_drop_reasserts_r4");

    // R10: sequenced channel 2 starts only after channel 1 good.
    p_ch2_after_ch1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && $stable(mode) && $rose(ch2_en)) |-> $past(fb1_good))
        else $error("p_ch2_after_ch1_r10");

    // R2: in sequenced modes the watchdog waits for both resets.
    p_wdog_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && wdog_start) |-> (rst1_n && rst2_n))
        else $error("p_wdog_both_r2");

    // R7: the watchdog level never stands without reset 1 released.
    p_wdog_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_start |-> rst1_n)
        else $error("p_wdog_level_r7");
endmodule

// File: tb/rst_seq_ctrl_tb.sv
// Directed bench for the reset sequencing controller.
module rst_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        fb1_good = 1'b0;
    logic        fb2_good = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic [23:0] tmo1 = '0;
    logic [23:0] tmo2 = '0;
    logic        ch1_en, ch2_en, rst1_n, rst2_n, wdog_start;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    rst_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .fb1_good(fb1_good), .fb2_good(fb2_good), .mode(mode),
        .tmo1(tmo1), .tmo2(tmo2),
        .ch1_en(ch1_en), .ch2_en(ch2_en), .rst1_n(rst1_n),
        .rst2_n(rst2_n), .wdog_start(wdog_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance n falling edges, then settle one time unit.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Bring the block to shutdown with all goods low.
    task automatic idle(input logic [1:0] m);
        @(negedge clk);
        enable = 1'b0; fb1_good = 1'b0; fb2_good = 1'b0; mode = m;
        step(1);
        @(negedge clk);
        enable = 1'b1;
        #1;
    endtask

    task automatic t_reset_state;
        #1;
        chk("R6 reset rst1_n", rst1_n, 0);
        chk("R6 reset rst2_n", rst2_n, 0);
        chk("R6 reset ch1_en", ch1_en, 0);
        chk("R6 reset ch2_en", ch2_en, 0);
        chk("R6 reset wdog", wdog_start, 0);
    endtask

    task automatic t_indep;
        tmo1 = 24'd5; tmo2 = 24'd3;
        idle(2'b01);
        chk("R10 ch1_en on", ch1_en, 1);
        chk("R10 ch2_en waits", ch2_en, 0);
        @(negedge clk); fb1_good = 1'b1;
        step(1);
        chk("R10 ch2_en after fb1", ch2_en, 1);
        step(4);
        chk("R1 rst1 low at P", rst1_n, 0);
        step(1);
        chk("R1 rst1 high at P+1", rst1_n, 1);
        chk("R2 rst2 own channel", rst2_n, 0);
        chk("R2 wdog waits for both", wdog_start, 0);
        @(negedge clk); fb2_good = 1'b1;
        step(1);
        tmo2 = 24'd40;
        step(2);
        chk("R9 rst2 low at P", rst2_n, 0);
        step(1);
        chk("R9 rst2 high at latched P+1", rst2_n, 1);
        chk("R2 wdog both released", wdog_start, 1);
        @(negedge clk); fb1_good = 1'b0; #1;
        chk("R4 rst1 drops at once", rst1_n, 0);
        chk("R7 wdog drops", wdog_start, 0);
        chk("R10 ch2_en stays", ch2_en, 1);
        chk("R2 rst2 unaffected", rst2_n, 1);
        @(negedge clk); fb1_good = 1'b1;
        step(5);
        chk("R4 full timeout again low", rst1_n, 0);
        step(1);
        chk("R4 full timeout again high", rst1_n, 1);
    endtask

    task automatic t_merged;
        tmo1 = 24'd4; tmo2 = 24'd1;
        idle(2'b00);
        @(negedge clk); fb1_good = 1'b1;
        step(1);
        chk("R10 merged ch2_en", ch2_en, 1);
        step(10);
        chk("R3 rst1 waits for fb2", rst1_n, 0);
        chk("R3 rst2 waits for fb2", rst2_n, 0);
        @(negedge clk); fb2_good = 1'b1;
        step(4);
        chk("R3 rst2 low at P", rst2_n, 0);
        step(1);
        chk("R3 rst1 high at P+1", rst1_n, 1);
        chk("R3 rst2 high with rst1", rst2_n, 1);
        chk("R3 wdog", wdog_start, 1);
        @(negedge clk); fb2_good = 1'b0; #1;
        chk("R3 fb2 drop rst1", rst1_n, 0);
        chk("R3 fb2 drop rst2", rst2_n, 0);
    endtask

    task automatic t_simul(input logic [1:0] m, input string req);
        tmo1 = 24'd2; tmo2 = 24'd6;
        idle(m);
        chk({req, " ch2_en with enable"}, ch2_en, 1);
        @(negedge clk); fb1_good = 1'b1;
        step(2);
        chk({req, " rst1 low at P"}, rst1_n, 0);
        step(1);
        chk({req, " rst1 high"}, rst1_n, 1);
        chk({req, " rst2 own channel"}, rst2_n, 0);
        chk({req, " wdog on rst1"}, wdog_start, 1);
    endtask

    task automatic t_zero_period;
        tmo1 = 24'd0;
        idle(2'b10);
        @(negedge clk); fb1_good = 1'b1; #1;
        chk("R1 P=0 before edge", rst1_n, 0);
        step(1);
        chk("R1 P=0 after one edge", rst1_n, 1);
    endtask

    task automatic t_shutdown;
        @(negedge clk); fb2_good = 1'b1;
        step(8);
        chk("R6 pre rst2 up", rst2_n, 1);
        @(negedge clk); enable = 1'b0; #1;
        chk("R6 rst1 low", rst1_n, 0);
        chk("R6 rst2 low", rst2_n, 0);
        chk("R6 ch1_en low", ch1_en, 0);
        chk("R6 ch2_en low", ch2_en, 0);
        chk("R6 wdog low", wdog_start, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_indep();
        t_merged();
        t_simul(2'b10, "R5");
        t_simul(2'b11, "R8");
        t_shutdown();
        t_zero_period();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule